// File: doc/BRIEF.md
# I2S Serial Audio Transmitter

This block turns 32-bit words written into a small transmit queue into an I2S serial stream. It drives a serial data line and a word-select line, one bit per pulse of a bit-clock tick that a divider outside the block supplies. Each queue word carries one 32-bit sample, two 16-bit samples or four 8-bit samples, and these are unpacked starting from the least significant end. Samples go out MSB first, one bit period after each word-select edge. Word select low carries the left channel and high carries the right channel.

Control pins set the following:
- sample width;
- stereo or mono output (mono sends each sample on both channels);
- a stop mode, which mutes the line and freezes the queue;
- a channel clear, which resets the channel and the queue asynchronously;
- master or slave timing;
- the word-select half period, written as the value minus one.

In master mode the block generates word select itself. In slave mode it follows an external word select, sampled on each tick.

Status pins report the queue fill level and three request flags. Each flag compares the level against its own threshold. Words enter on a valid/ready port. A word is accepted on a clock edge where both `in_valid` and `in_ready` are high. `in_ready` drops while the queue is full or stop is set. A held word waits without loss until it is accepted.

Top module: `i2s_tx_core`

## Requirements
- R1: The queue holds DEPTH (8) words of 32 bits. A word is taken on a clock edge with in_valid and in_ready both high. `in_ready` is low while 8 words are held. `fifo_level` gives the held count one cycle after each push or pop.
- R2: In master mode (`cfg_slave`=0), `ws_out` toggles on every (cfg_ws_half+1)-th bit tick, so a value of 31 gives a 64-tick word-select period.
- R3: In slave mode (`cfg_slave`=1), `ws_in` is sampled on each bit tick and shows on `ws_out`. Every change seen starts a new channel slot.
- R4: Each slot starts with a word-select change on a tick. `sd_out` carries the previous slot's last bit on that tick, then the new sample MSB first from the next tick onward. Bits past the sample width are zero. Low word select is left, high is right.
- R5: `cfg_width` 00 selects four 8-bit samples per word, 01 two 16-bit samples, and 11 one 32-bit sample. Samples are taken from bit 0 upward. The reserved code 10 acts as 32-bit.
- R6: In stereo (`cfg_mono`=0), each slot takes the next sample in order. In mono, a left slot takes the next sample and the right slot that follows repeats it. A word is popped once its last sample has been taken.
- R7: While `cfg_stop`=1, `in_ready` is low, nothing is popped, and `sd_out` is 0 after every tick.
- R8: A slot that starts with the queue empty sends all zeros and consumes nothing.
- R9: `cfg_chan_rst`=1 clears the queue, the level, the word-select state and `sd_out` at once, without waiting for a clock edge.
- R10: `irq` is high when fifo_level <= cfg_irq_lvl. `dma_req1` is high when fifo_level <= cfg_dma1_lvl. `dma_req2` is high when fifo_level <= cfg_dma2_lvl.
- R11: While `rst_n` is low, `fifo_level`, `ws_out` and `sd_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_width | input | 2 | Sample width code |
| cfg_mono | input | 1 | 1 = mono, 0 = stereo |
| cfg_stop | input | 1 | Mute and freeze the queue |
| cfg_chan_rst | input | 1 | Asynchronous channel and queue clear |
| cfg_slave | input | 1 | 0 = master, 1 = slave word select |
| cfg_ws_half | input | HALF_W (9) | Word-select half period minus one |
| cfg_irq_lvl | input | LVL_W (4) | Interrupt threshold |
| cfg_dma1_lvl | input | LVL_W (4) | First request threshold |
| cfg_dma2_lvl | input | LVL_W (4) | Second request threshold |
| in_data | input | WORD_W (32) | Queue word |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be taken |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| ws_in | input | 1 | External word select (slave) |
| ws_out | output | 1 | Word select in use |
| sd_out | output | 1 | Serial data |
| irq | output | 1 | Interrupt flag |
| dma_req1 | output | 1 | First request flag |
| dma_req2 | output | 1 | Second request flag |
| fifo_level | output | LVL_W (4) | Held word count |

## Verification
`fifo_level` and `in_ready` settle one clock after an accepted push. The channel clear acts on them within the same cycle. `ws_out` and `sd_out` change only at the clock edge where `bit_tick` is high, and the MSB of a sample appears on the tick after the word-select change that opens its slot. The bench therefore drives ticks itself and samples both serial lines on the falling edge after each tick. Each slot is closed on the tick where word select changes again, and is then compared with the next expected sample. Level and flag checks are made on falling edges after the pushes have landed, or 1 ns after the clear is raised.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  typedef enum logic [1:0] {
    SW_8   = 2'b00,
    SW_16  = 2'b01,
    SW_RSV = 2'b10,
    SW_32  = 2'b11
  } samp_w_e;

endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_q, rd_q;
  logic [LVL_W-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= nxt(wr_q);
      if (pop)  rd_q <= nxt(rd_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + LVL_W'(1);
        2'b01:   cnt_q <= cnt_q - LVL_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head  = mem[rd_q];
  assign level = cnt_q;
  assign full  = (cnt_q == LVL_W'(DEPTH));
  assign empty = (cnt_q == '0);

endmodule

// File: rtl/i2s_tx_wsgen.sv
module i2s_tx_wsgen #(
  parameter int HALF_W = 9
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              tick,
  input  logic              slave,
  input  logic [HALF_W-1:0] half,
  input  logic              ws_in,
  output logic              ws_o,
  output logic              ev_o,
  output logic              chan_o
);
  logic [HALF_W-1:0] cnt_q;
  logic              ws_q;
  logic              wrap;

  assign wrap = (cnt_q >= half);

  // Slot boundary for this tick and the channel it opens
  always_comb begin
    if (slave) begin
      ev_o   = tick && (ws_in != ws_q);
      chan_o = ws_in;
    end else begin
      ev_o   = tick && wrap;
      chan_o = ~ws_q;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
      ws_q  <= 1'b0;
    end else if (tick) begin
      if (slave) begin
        ws_q  <= ws_in;
        cnt_q <= '0;
      end else if (wrap) begin
        ws_q  <= ~ws_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + HALF_W'(1);
      end
    end
  end

  assign ws_o = ws_q;

endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
  import i2s_tx_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              tick,
  input  logic              ev,
  input  logic              chan,
  input  logic              stop,
  input  logic              mono,
  input  logic [1:0]        width,
  input  logic [WORD_W-1:0] head,
  input  logic              empty,
  output logic              pop,
  output logic              sd_o
);
  localparam int SUB_W = $clog2(WORD_W / 8);

  logic [SUB_W-1:0]  sub_q, last_sub;
  logic [WORD_W-1:0] shreg_q, held_q, fetched, load_w;
  logic              take, sd_q;

  // Pick the current sample out of the head word, left-aligned
  always_comb begin
    case (width)
      SW_8: begin
        fetched  = {head[8*sub_q +: 8], {(WORD_W-8){1'b0}}};
        last_sub = SUB_W'(WORD_W / 8 - 1);
      end
      SW_16: begin
        fetched  = {head[16*sub_q[SUB_W-2:0] +: 16], {(WORD_W-16){1'b0}}};
        last_sub = SUB_W'(WORD_W / 16 - 1);
      end
      default: begin
        fetched  = head;
        last_sub = '0;
      end
    endcase
  end

  assign take = ev && !stop && !empty && (!mono || !chan);
  assign pop  = take && (sub_q >= last_sub);

  always_comb begin
    if (stop)              load_w = '0;
    else if (mono && chan) load_w = held_q;
    else if (take)         load_w = fetched;
    else                   load_w = '0;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sub_q   <= '0;
      held_q  <= '0;
      shreg_q <= '0;
      sd_q    <= 1'b0;
    end else begin
      if (take) sub_q <= pop ? '0 : sub_q + SUB_W'(1);
      if (ev && mono && !chan) held_q <= take ? fetched : '0;
      if (tick) begin
        sd_q    <= stop ? 1'b0 : shreg_q[WORD_W-1];
        shreg_q <= ev ? load_w : {shreg_q[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign sd_o = sd_q;

endmodule

// File: rtl/i2s_tx_core.sv
module i2s_tx_core #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 32,
  parameter int HALF_W = 9,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_mono,
  input  logic              cfg_stop,
  input  logic              cfg_chan_rst,
  input  logic              cfg_slave,
  input  logic [HALF_W-1:0] cfg_ws_half,
  input  logic [LVL_W-1:0]  cfg_irq_lvl,
  input  logic [LVL_W-1:0]  cfg_dma1_lvl,
  input  logic [LVL_W-1:0]  cfg_dma2_lvl,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              bit_tick,
  input  logic              ws_in,
  output logic              ws_out,
  output logic              sd_out,
  output logic              irq,
  output logic              dma_req1,
  output logic              dma_req2,
  output logic [LVL_W-1:0]  fifo_level
);
  logic              arst_n;
  logic              push, pop, full, empty;
  logic              ev, chan;
  logic [WORD_W-1:0] head;

  assign arst_n   = rst_n & ~cfg_chan_rst;
  assign in_ready = !cfg_stop && !full;
  assign push     = in_valid && in_ready;

  i2s_tx_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W), .LVL_W(LVL_W)) fifo_i (
    .clk(clk), .arst_n(arst_n), .push(push), .din(in_data), .pop(pop),
    .head(head), .level(fifo_level), .full(full), .empty(empty)
  );

  i2s_tx_wsgen #(.HALF_W(HALF_W)) wsgen_i (
    .clk(clk), .arst_n(arst_n), .tick(bit_tick), .slave(cfg_slave),
    .half(cfg_ws_half), .ws_in(ws_in), .ws_o(ws_out), .ev_o(ev), .chan_o(chan)
  );

  i2s_tx_serializer #(.WORD_W(WORD_W)) ser_i (
    .clk(clk), .arst_n(arst_n), .tick(bit_tick), .ev(ev), .chan(chan),
    .stop(cfg_stop), .mono(cfg_mono), .width(cfg_width), .head(head),
    .empty(empty), .pop(pop), .sd_o(sd_out)
  );

  assign irq      = (fifo_level <= cfg_irq_lvl);
  assign dma_req1 = (fifo_level <= cfg_dma1_lvl);
  assign dma_req2 = (fifo_level <= cfg_dma2_lvl);

endmodule

// File: rtl/i2s_tx_core_chk.sv
module i2s_tx_core_chk #(
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_chan_rst,
  input logic             cfg_stop,
  input logic             bit_tick,
  input logic             in_valid,
  input logic             in_ready,
  input logic             ws_out,
  input logic             sd_out,
  input logic [LVL_W-1:0] fifo_level
);
  a_r1_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n || cfg_chan_rst)
    (in_valid && fifo_level == LVL_W'(DEPTH)) |-> !in_ready);

  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n || cfg_chan_rst)
    fifo_level <= LVL_W'(DEPTH));

  a_r7_stop_mutes: assert property (@(posedge clk) disable iff (!rst_n || cfg_chan_rst)
    (cfg_stop && bit_tick) |=> (sd_out == 1'b0));

  a_r7_stop_freezes_level: assert property (@(posedge clk) disable iff (!rst_n || cfg_chan_rst)
    cfg_stop |=> $stable(fifo_level));

  a_r8_empty_stays_empty: assert property (@(posedge clk) disable iff (!rst_n || cfg_chan_rst)
    (fifo_level == '0 && !(in_valid && in_ready)) |=> (fifo_level == '0));

  a_r4_sd_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n || cfg_chan_rst)
    !bit_tick |=> $stable(sd_out));

  a_r2_ws_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n || cfg_chan_rst)
    !bit_tick |=> $stable(ws_out));

endmodule

bind i2s_tx_core i2s_tx_core_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_chan_rst(cfg_chan_rst), .cfg_stop(cfg_stop),
  .bit_tick(bit_tick), .in_valid(in_valid), .in_ready(in_ready),
  .ws_out(ws_out), .sd_out(sd_out), .fifo_level(fifo_level)
);

// File: tb/i2s_tx_core_tb_top.sv
module i2s_tx_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_width = 2'b01;
  logic        cfg_mono = 1'b0, cfg_stop = 1'b0, cfg_chan_rst = 1'b0, cfg_slave = 1'b0;
  logic [8:0]  cfg_ws_half = 9'd31;
  logic [3:0]  cfg_irq_lvl = 4'd2, cfg_dma1_lvl = 4'd5, cfg_dma2_lvl = 4'd0;
  logic [31:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        bit_tick = 1'b0;
  logic        ws_in = 1'b0;
  logic        ws_out, sd_out, irq, dma_req1, dma_req2;
  logic [3:0]  fifo_level;

  always #5 clk = ~clk;

  i2s_tx_core dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_mono(cfg_mono),
    .cfg_stop(cfg_stop), .cfg_chan_rst(cfg_chan_rst), .cfg_slave(cfg_slave),
    .cfg_ws_half(cfg_ws_half), .cfg_irq_lvl(cfg_irq_lvl), .cfg_dma1_lvl(cfg_dma1_lvl),
    .cfg_dma2_lvl(cfg_dma2_lvl), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .bit_tick(bit_tick), .ws_in(ws_in), .ws_out(ws_out),
    .sd_out(sd_out), .irq(irq), .dma_req1(dma_req1), .dma_req2(dma_req2),
    .fifo_level(fifo_level)
  );

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  logic [31:0] wbuf[8];
  string cur_req = "R4";
  int edges = 0, r_edges = 0, last_len = 0, ones = 0, n = 0, tcnt = 0, scnt = 0;
  bit watch = 0, armed = 0, slave_gen = 0;
  logic prev_ws = 1'b0;
  logic [31:0] slot = '0, e_raw, e_cmp;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Monitor and tick source: observe after each tick edge, then schedule the next tick
  always @(negedge clk) begin
    if (rst_n && bit_tick) begin
      if (watch && sd_out) ones++;
      slot = {slot[30:0], sd_out};
      n++;
      if (ws_out != prev_ws) begin
        if (armed && exp_q.size() > 0) begin
          e_raw = exp_q.pop_front();
          e_cmp = (n >= 32) ? e_raw : (e_raw >> (32 - n));
          chk(slot == e_cmp, cur_req, "slot data", slot, e_cmp);
        end
        last_len = n;
        edges++;
        if (ws_out) r_edges++;
        armed = (exp_q.size() > 0);
        slot = '0;
        n = 0;
      end
      prev_ws = ws_out;
    end
    tcnt++;
    if (tcnt % 4 == 0) begin
      bit_tick = 1'b1;
      if (slave_gen) begin
        scnt++;
        if (scnt % 16 == 0) ws_in = ~ws_in;
      end
    end else begin
      bit_tick = 1'b0;
    end
  end

  task automatic push_word(input logic [31:0] w);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_data  = w;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_edges(input int k);
    int e0;
    e0 = edges;
    wait (edges >= e0 + k);
  endtask

  task automatic wait_right();
    int r0;
    r0 = r_edges;
    wait (r_edges != r0);
  endtask

  // Scoreboard driver: expected slots first, then the words
  task automatic run_stream(input logic [1:0] w, input bit mono, input int cnt, input string req);
    int ss, ns;
    ss = (w == 2'b00) ? 8 : (w == 2'b01) ? 16 : 32;
    ns = 32 / ss;
    cfg_width = w;
    cfg_mono  = mono;
    cur_req   = req;
    wait_right();
    for (int i = 0; i < cnt; i++) begin
      for (int k = 0; k < ns; k++) begin
        logic [31:0] s;
        s = wbuf[i] >> (k * ss);
        if (ss < 32) s = s & ((32'h1 << ss) - 32'h1);
        s = s << (32 - ss);
        exp_q.push_back(s);
        if (mono) exp_q.push_back(s);
      end
    end
    for (int i = 0; i < cnt; i++) push_word(wbuf[i]);
    wait (exp_q.size() == 0);
    wait_edges(2);
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    cfg_chan_rst = 1'b1;
    @(negedge clk);
    cfg_chan_rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R4", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(fifo_level == 0, "R11", "level in reset", fifo_level, 0);
    chk(ws_out == 0, "R11", "ws in reset", ws_out, 0);
    chk(sd_out == 0, "R11", "sd in reset", sd_out, 0);
    chk(irq == 1, "R10", "irq at level 0", irq, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5 16-bit stereo, R2 64-tick frame
    wbuf[0] = 32'h1234_ABCD; wbuf[1] = 32'h8001_7FFE;
    run_stream(2'b01, 1'b0, 2, "R5");
    chk(last_len == 32, "R2", "slot length half=31", last_len, 32);

    // R5 8-bit stereo
    wbuf[0] = 32'hF10A_5C3B;
    run_stream(2'b00, 1'b0, 1, "R5");

    // R6 32-bit mono and 16-bit mono
    wbuf[0] = 32'hDEAD_BEEF; wbuf[1] = 32'h0000_0001;
    run_stream(2'b11, 1'b1, 2, "R6");
    wbuf[0] = 32'hAAAA_5555;
    run_stream(2'b01, 1'b1, 1, "R6");

    // R5 reserved code acts as 32-bit
    wbuf[0] = 32'h8765_4321; wbuf[1] = 32'hC000_0003;
    run_stream(2'b10, 1'b0, 2, "R5");

    // R8 empty queue sends zeros
    cfg_width = 2'b11; cfg_mono = 1'b0;
    ones = 0; watch = 1;
    wait_edges(3);
    watch = 0;
    chk(ones == 0, "R8", "ones while empty", ones, 0);
    chk(fifo_level == 0, "R8", "level while empty", fifo_level, 0);

    // R2 short frame
    cfg_ws_half = 9'd7;
    wait_edges(3);
    wbuf[0] = 32'h3C5A_96E1;
    run_stream(2'b00, 1'b0, 1, "R2");
    chk(last_len == 8, "R2", "slot length half=7", last_len, 8);
    cfg_ws_half = 9'd31;
    wait_edges(3);

    // R3 slave timing from ws_in
    slave_gen = 1; cfg_slave = 1'b1;
    wait_edges(3);
    wbuf[0] = 32'h4B1D_F00D;
    run_stream(2'b01, 1'b0, 1, "R3");
    chk(last_len == 16, "R3", "slave slot length", last_len, 16);
    cfg_slave = 1'b0; slave_gen = 0;
    wait_edges(3);

    // R1 and R10 level, thresholds, full
    cfg_width = 2'b11; cfg_irq_lvl = 4'd4; cfg_dma1_lvl = 4'd5; cfg_dma2_lvl = 4'd2;
    wait_right();
    for (int i = 0; i < 5; i++) push_word(32'h1111_0000 + i);
    @(negedge clk);
    chk(fifo_level == 5, "R1", "level after 5 pushes", fifo_level, 5);
    chk(irq == 0, "R10", "irq level 5 thr 4", irq, 0);
    chk(dma_req1 == 1, "R10", "dma1 level 5 thr 5", dma_req1, 1);
    chk(dma_req2 == 0, "R10", "dma2 level 5 thr 2", dma_req2, 0);
    for (int i = 0; i < 3; i++) push_word(32'h2222_0000 + i);
    @(negedge clk);
    chk(fifo_level == 8, "R1", "level when full", fifo_level, 8);
    chk(in_ready == 0, "R1", "ready when full", in_ready, 0);

    // R9 asynchronous clear
    @(negedge clk);
    cfg_chan_rst = 1'b1;
    #1;
    chk(fifo_level == 0, "R9", "level on clear", fifo_level, 0);
    chk(ws_out == 0, "R9", "ws on clear", ws_out, 0);
    chk(sd_out == 0, "R9", "sd on clear", sd_out, 0);
    chk(irq && dma_req1 && dma_req2, "R10", "flags at level 0", {irq, dma_req1, dma_req2}, 3'b111);
    @(negedge clk);
    cfg_chan_rst = 1'b0;
    wait_edges(3);

    // R7 stop mutes and freezes
    wait_right();
    push_word(32'hFFFF_FFFF);
    push_word(32'hFFFF_FFFF);
    wait_edges(1);
    @(negedge clk);
    chk(fifo_level == 1, "R6", "one word popped", fifo_level, 1);
    repeat (20) @(negedge clk);
    cfg_stop = 1'b1;
    repeat (12) @(negedge clk);
    ones = 0; watch = 1;
    chk(in_ready == 0, "R7", "ready while stopped", in_ready, 0);
    in_data = 32'h5555_5555; in_valid = 1'b1;
    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    wait_edges(3);
    watch = 0;
    chk(ones == 0, "R7", "ones while stopped", ones, 0);
    chk(fifo_level == 1, "R7", "level while stopped", fifo_level, 1);
    pulse_clear();
    cfg_stop = 1'b0;
    repeat (4) @(negedge clk);
    chk(fifo_level == 0, "R9", "level after clear", fifo_level, 0);

    finish_run();
  end
endmodule